// File: doc/BRIEF.md
# Software Store Command Detector

This block watches the accesses that a host makes to a small static memory and recognises a fixed chain of six reads as a command to save the memory contents to nonvolatile storage. Every clock cycle in which a read strobe or a write strobe is high counts as one completed access on the address bus. When the six required read addresses arrive in order, with no other access between them, the block issues a one-cycle store request. Ordinary reads and writes still reach the memory unchanged. The block only sees them, so a host that never sends the chain sees a plain 2K x 8 SRAM.

The six addresses and the bus width are parameters. The address chain is packed with step one in the least significant slice. A `busy` input comes from the store engine. While `busy` is high, the detector ignores all accesses and stays at its start position, so nothing typed during a store can count. A debug output shows how many steps of the chain have matched so far.

The access interface is a plain strobe interface. It has no valid/ready handshake and no back-pressure: the block never stalls the bus, and it judges each access in the cycle that access is presented.

Top module: `swstore_seq_detect`

## Requirements
- R1: While `rst` is high at a rising edge, `seq_pos` becomes 0 and `store_req` becomes 0 after that edge.
- R2: A read whose address matches step six (default 0x70F), taken while `seq_pos` is 5, drives `store_req` high for exactly the one cycle after that edge.
- R3: A read (`rd_stb`=1, `wr_stb`=0) whose address equals the step indexed by the current `seq_pos` raises `seq_pos` by one when `seq_pos` is below 5. The steps are indexed 0 to 5, and the default step addresses are 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0, 0x70F.
- R4: Any cycle with `wr_stb`=1 returns `seq_pos` to 0 with no store request. This holds even when `rd_stb` is also high.
- R5: A read whose address is not the expected next step sets `seq_pos` to 1 if the address is step one (0x000) and to 0 otherwise. No store request is issued.
- R6: While `busy` is high, every access is ignored, `seq_pos` is 0 after the edge, and no store request is issued.
- R7: A cycle with neither strobe high leaves `seq_pos` unchanged.
- R8: After a store request, `seq_pos` is 0, so the next command needs all six reads again.
- R9: Each cycle with a strobe high is a separate access. Two reads in a row at the same address are judged one at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Completed read access this cycle |
| wr_stb | input | 1 | Completed write access this cycle |
| addr | input | ADDR_W (11) | Access address |
| busy | input | 1 | Store in progress; ignore accesses and hold at start |
| store_req | output | 1 | One-cycle store command pulse |
| seq_pos | output | POS_W (3) | Number of chain steps matched so far |

## Verification
The bench builds the block with its default parameters: an 11-bit address and the six-step chain. These are small enough to sweep every one of the 2048 addresses as the next read at each of the six positions. Each position is also swept with writes and with both strobes high together. With these defaults the bench covers every match, every abort, and the restart on 0x000. It also exercises the final step that fires, busy masking, idle gaps and back-to-back repeats.

// File: rtl/swstore_pkg.sv
package swstore_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/sqd_access_classify.sv
module sqd_access_classify
  import swstore_pkg::*;
(
  input  logic      rd_stb,
  input  logic      wr_stb,
  input  logic      busy,
  output acc_kind_e kind
);
  // A write always wins: a cycle with both strobes counts as a write.
  always_comb begin
    kind = ACC_NONE;
    if (!busy) begin
      if (wr_stb)      kind = ACC_WRITE;
      else if (rd_stb) kind = ACC_READ;
    end
  end
endmodule

// File: rtl/sqd_addr_match.sv
module sqd_addr_match #(
  parameter int ADDR_W = 11,
  parameter int SEQ_LEN = 6,
  parameter logic [SEQ_LEN*ADDR_W-1:0] SEQ_CODES = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [SEQ_LEN-1:0] hit
);
  // One comparator per chain step, all working in parallel.
  for (genvar g = 0; g < SEQ_LEN; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] CODE = SEQ_CODES[g*ADDR_W +: ADDR_W];
    assign hit[g] = (addr == CODE);
  end
endmodule

// File: rtl/sqd_step_tracker.sv
module sqd_step_tracker
  import swstore_pkg::*;
#(
  parameter int SEQ_LEN = 6,
  parameter int POS_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busy,
  input  acc_kind_e          kind,
  input  logic [SEQ_LEN-1:0] hit,
  output logic [POS_W-1:0]   pos,
  output logic               fire
);
  localparam logic [POS_W-1:0] LAST = POS_W'(SEQ_LEN - 1);
  localparam logic [POS_W-1:0] ONE  = POS_W'(1);

  logic [POS_W-1:0] pos_n;
  logic             fire_n;

  always_comb begin
    pos_n  = pos;
    fire_n = 1'b0;
    if (busy) begin
      pos_n = '0;
    end else begin
      unique case (kind)
        ACC_READ: begin
          if (hit[pos]) begin
            if (pos == LAST) begin
              fire_n = 1'b1;
              pos_n  = '0;
            end else begin
              pos_n = pos + ONE;
            end
          end else begin
            // The aborting read may itself open a fresh chain.
            pos_n = hit[0] ? ONE : '0;
          end
        end
        ACC_WRITE: pos_n = '0;
        default:   pos_n = pos;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      fire <= 1'b0;
    end else begin
      pos  <= pos_n;
      fire <= fire_n;
    end
  end
endmodule

// File: rtl/swstore_seq_detect.sv
module swstore_seq_detect
  import swstore_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SEQ_LEN = 6,
  parameter logic [SEQ_LEN*ADDR_W-1:0] SEQ_CODES =
    {11'h70F, 11'h0F0, 11'h7FF, 11'h2AA, 11'h555, 11'h000},
  localparam int POS_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              store_req,
  output logic [POS_W-1:0]  seq_pos
);
  acc_kind_e          kind;
  logic [SEQ_LEN-1:0] hit;

  sqd_access_classify u_cls (
    .rd_stb (rd_stb),
    .wr_stb (wr_stb),
    .busy   (busy),
    .kind   (kind)
  );

  sqd_addr_match #(
    .ADDR_W    (ADDR_W),
    .SEQ_LEN   (SEQ_LEN),
    .SEQ_CODES (SEQ_CODES)
  ) u_match (
    .addr (addr),
    .hit  (hit)
  );

  sqd_step_tracker #(
    .SEQ_LEN (SEQ_LEN),
    .POS_W   (POS_W)
  ) u_trk (
    .clk  (clk),
    .rst  (rst),
    .busy (busy),
    .kind (kind),
    .hit  (hit),
    .pos  (seq_pos),
    .fire (store_req)
  );
endmodule

// File: rtl/sqd_checker.sv
module sqd_checker #(
  parameter int ADDR_W = 11,
  parameter int SEQ_LEN = 6,
  parameter logic [SEQ_LEN*ADDR_W-1:0] SEQ_CODES = '0,
  parameter int POS_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              store_req,
  input logic [POS_W-1:0]  seq_pos
);
  localparam logic [POS_W-1:0]  LAST  = POS_W'(SEQ_LEN - 1);
  localparam logic [POS_W-1:0]  ONE   = POS_W'(1);
  localparam logic [ADDR_W-1:0] FIRST = SEQ_CODES[ADDR_W-1:0];

  logic [ADDR_W-1:0] want;
  logic              rd_only;
  assign want    = SEQ_CODES[seq_pos*ADDR_W +: ADDR_W];
  assign rd_only = !busy && rd_stb && !wr_stb;

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      assert_reset_clear_R1: assert (seq_pos == '0 && !store_req)
        else $error("R1 reset did not clear state");
    end
  end

  assert_fire_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_only && seq_pos == LAST && addr == want) |=> store_req);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req);

  assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_only && seq_pos != LAST && addr == want) |=> (seq_pos == $past(seq_pos) + ONE));

  assert_write_abort_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_stb) |=> (seq_pos == '0 && !store_req));

  assert_mismatch_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_only && addr != want) |=>
      (!store_req && seq_pos == (($past(addr) == FIRST) ? ONE : '0)));

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> (seq_pos == '0 && !store_req));

  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !rd_stb && !wr_stb) |=> $stable(seq_pos));

  assert_post_fire_R8: assert property (@(posedge clk) disable iff (rst)
    store_req |-> seq_pos == '0);
endmodule

bind swstore_seq_detect sqd_checker #(
  .ADDR_W    (ADDR_W),
  .SEQ_LEN   (SEQ_LEN),
  .SEQ_CODES (SEQ_CODES),
  .POS_W     (POS_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_stb    (rd_stb),
  .wr_stb    (wr_stb),
  .addr      (addr),
  .busy      (busy),
  .store_req (store_req),
  .seq_pos   (seq_pos)
);

// File: tb/sim_swstore_seq_detect.sv
`timescale 1ns/1ps
module sim_swstore_seq_detect;
  localparam int AW = 11;
  localparam int NSTEP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_stb = 1'b0;
  logic wr_stb = 1'b0;
  logic [AW-1:0] addr = '0;
  logic busy = 1'b0;
  logic store_req;
  logic [2:0] seq_pos;

  int total = 0;
  int bad = 0;
  int m_pos = 0;

  always #10 clk = ~clk;

  swstore_seq_detect u0 (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .addr(addr), .busy(busy), .store_req(store_req), .seq_pos(seq_pos)
  );

  function automatic logic [AW-1:0] code(int i);
    case (i)
      0: return 11'h000;
      1: return 11'h555;
      2: return 11'h2AA;
      3: return 11'h7FF;
      4: return 11'h0F0;
      default: return 11'h70F;
    endcase
  endfunction

  task automatic check(string req, int got_pos, int exp_pos, bit got_r, bit exp_r);
    total++;
    if (got_pos != exp_pos || got_r != exp_r) begin
      bad++;
      $display("FAIL %s pos=%0d exp=%0d req=%0b exp=%0b", req, got_pos, exp_pos, got_r, exp_r);
    end
  endtask

  // One cycle of stimulus; the result is checked at the next falling edge.
  task automatic step(bit r, bit w, logic [AW-1:0] a, bit b, string req);
    bit exp_r = 1'b0;
    rd_stb = r; wr_stb = w; addr = a; busy = b;
    if (b) m_pos = 0;
    else if (w) m_pos = 0;
    else if (r) begin
      if (a == code(m_pos)) begin
        if (m_pos == NSTEP - 1) begin exp_r = 1'b1; m_pos = 0; end
        else m_pos = m_pos + 1;
      end else m_pos = (a == code(0)) ? 1 : 0;
    end
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0; busy = 1'b0;
    check(req, int'(seq_pos), m_pos, store_req, exp_r);
  endtask

  task automatic prefix(int k);
    for (int i = 0; i < k; i++) step(1, 0, code(i), 0, "R3");
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired pos=%0d exp=done", seq_pos);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1", int'(seq_pos), 0, store_req, 1'b0);
    // R1: reset in the middle of a chain
    rst = 1'b0;
    prefix(3);
    rst = 1'b1;
    @(negedge clk);
    m_pos = 0;
    check("R1", int'(seq_pos), 0, store_req, 1'b0);
    rst = 1'b0;

    // R2, R8: full chain fires once, then back-to-back second chain
    prefix(5);
    step(1, 0, code(5), 0, "R2");
    step(0, 0, '0, 0, "R2");
    prefix(5);
    step(1, 0, code(5), 0, "R8");

    // R7: idle gaps between chain reads
    for (int i = 0; i < NSTEP; i++) begin
      step(1, 0, code(i), 0, "R7");
      step(0, 0, 11'h3C3, 0, "R7");
      step(0, 0, code(i), 0, "R7");
    end

    // R6: busy during whole chain, and busy mid-chain
    for (int i = 0; i < NSTEP; i++) step(1, 0, code(i), 1, "R6");
    prefix(4);
    step(1, 0, code(4), 1, "R6");
    step(1, 0, code(5), 0, "R6");

    // R9: repeated strobes at the same address
    step(1, 0, code(0), 0, "R9");
    step(1, 0, code(0), 0, "R9");
    step(1, 0, code(1), 0, "R9");
    step(1, 0, code(1), 0, "R9");

    // R4: write or both strobes at each position, including matching addresses
    for (int k = 0; k < NSTEP; k++) begin
      step(0, 0, '0, 1, "R6");
      prefix(k);
      step(0, 1, code(k), 0, "R4");
      step(0, 0, '0, 1, "R6");
      prefix(k);
      step(1, 1, code(k), 0, "R4");
    end

    // R3, R5, R2: every address as the next read at every position
    for (int k = 0; k < NSTEP; k++) begin
      for (int a = 0; a < (1 << AW); a++) begin
        step(0, 0, '0, 1, "R6");
        prefix(k);
        step(1, 0, AW'(a), 0, (AW'(a) == code(k)) ? ((k == NSTEP - 1) ? "R2" : "R3") : "R5");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule